// File: doc/BRIEF.md
# CAN Bus-Off Recovery Monitor

This block decides when a CAN node that has gone bus-off may return to the error-active state. While the node is bus-off, it watches the sampled receive bit stream and counts runs of eleven consecutive recessive bits. A dominant bit breaks the current run. Once 128 such runs have been seen, the recovery condition is met.

Two recovery policies are available, chosen by a mode input. In the automatic policy, which applies when the mode input is low, the node leaves bus-off as soon as the count is reached. In the user-gated policy, recovery also needs software to clear a hold flag. Hardware sets that flag when the node enters bus-off. The count and the hold clear may happen in either order. On recovery, the block drops its bus-off status, clears its counters and emits a one-cycle completion pulse.

Top module: `can_busoff_recovery`

## Requirements
- R1: After reset, `busoff_o`, `hold_o` and `recovered_o` are all 0.
- R2: A pulse on `busoff_enter_i` sets `busoff_o` and `hold_o` at the next clock edge. It also restarts both the run count and the sequence count from zero, and this applies even when the node is already bus-off.
- R3: While bus-off, each strobe on `bit_valid_i` with `bit_val_i` = 1 (recessive) adds one to the run. When the eleventh recessive bit arrives, one occurrence is counted and the run restarts from zero.
- R4: A strobed dominant bit (`bit_val_i` = 0) sets the run back to zero and leaves the occurrence count unchanged. Cycles without a strobe change nothing.
- R5: With `user_mode_i` = 0, `busoff_o` falls at the clock edge after the edge that counted the 128th occurrence. The value of `hold_o` has no effect in this mode.
- R6: With `user_mode_i` = 1, `busoff_o` stays high while `hold_o` is 1, even after 128 occurrences have been counted.
- R7: With `user_mode_i` = 1, recovery happens at the edge after both conditions hold: 128 occurrences counted and `hold_o` = 0. The two conditions may become true in either order.
- R8: A cycle with `hold_clr_i` = 1 clears `hold_o` at the next edge. If `busoff_enter_i` is also high in that cycle, the entry wins and `hold_o` is set.
- R9: `recovered_o` is high for exactly the one cycle in which `busoff_o` first reads 0 after recovery. Any later bus-off needs a full 128 new occurrences.
- R10: Bits strobed while the node is not bus-off have no effect on any later count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_valid_i | input | 1 | One-cycle strobe marking a sampled bus bit |
| bit_val_i | input | 1 | Sampled bit value, 1 = recessive |
| busoff_enter_i | input | 1 | Pulse: the node has entered bus-off |
| user_mode_i | input | 1 | 0 = automatic recovery, 1 = user-gated recovery |
| hold_clr_i | input | 1 | User write of one to the hold flag, which clears it |
| busoff_o | output | 1 | Node is bus-off |
| hold_o | output | 1 | Hold flag |
| recovered_o | output | 1 | One-cycle pulse when recovery completes |

## Verification
The hardest situations to reach are the ones at the end of a full count of 128 runs of eleven bits, which is about 1400 strobes. Examples are the user-gated case where the count finishes long before the hold is cleared, and a re-entry to bus-off that arrives midway through a count. The stimulus reaches them with tasks that emit whole runs, with dominant bits inserted just short of a complete run. It stops one bit before the 128th occurrence to check that the node is still bus-off, then either finishes the count or issues the clear. A behavioural model compares all three outputs on every cycle, so the exact recovery edge and the width of the completion pulse are both checked.

// File: rtl/can_bor_pkg.sv
package can_bor_pkg;
  typedef enum logic {
    POL_AUTO = 1'b0,
    POL_USER = 1'b1
  } bor_policy_e;
endpackage

// File: rtl/can_bor_run_cnt.sv
module can_bor_run_cnt #(
  parameter int RUN_LEN = 11
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic active_i,
  input  logic bit_valid_i,
  input  logic bit_val_i,
  output logic occ_o
);
  localparam int RUN_W = $clog2(RUN_LEN);
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(RUN_LEN - 1);

  logic [RUN_W-1:0] run_q;
  logic             strobe;

  assign strobe = active_i && bit_valid_i && !clear_i;
  assign occ_o  = strobe && bit_val_i && (run_q == RUN_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 run_q <= '0;
    else if (clear_i)            run_q <= '0;
    else if (strobe) begin
      if (!bit_val_i || occ_o)   run_q <= '0;
      else                       run_q <= run_q + 1'b1;
    end
  end

  AST_RUN_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q <= RUN_LAST) else $error("run out of range"); // R3
  AST_DOM_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && bit_valid_i && !bit_val_i) |=> run_q == '0) else $error("dominant kept run"); // R4
endmodule

// File: rtl/can_bor_seq_cnt.sv
module can_bor_seq_cnt #(
  parameter int SEQ_TARGET = 128
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic inc_i,
  output logic done_o
);
  localparam int SEQ_W = $clog2(SEQ_TARGET + 1);
  localparam logic [SEQ_W-1:0] SEQ_FULL = SEQ_W'(SEQ_TARGET);

  logic [SEQ_W-1:0] seq_q;

  assign done_o = (seq_q == SEQ_FULL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               seq_q <= '0;
    else if (clear_i)          seq_q <= '0;
    else if (inc_i && !done_o) seq_q <= seq_q + 1'b1;
  end

  AST_SEQ_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_q <= SEQ_FULL) else $error("sequence count overflow"); // R5
  AST_SEQ_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> seq_q == '0) else $error("count not cleared"); // R9
endmodule

// File: rtl/can_bor_ctrl.sv
module can_bor_ctrl
  import can_bor_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enter_i,
  input  logic user_mode_i,
  input  logic hold_clr_i,
  input  logic seq_done_i,
  output logic busoff_o,
  output logic hold_o,
  output logic recovered_o,
  output logic clear_o,
  output logic active_o
);
  bor_policy_e policy;
  logic        busoff_q, hold_q, rec_q, release_ok;

  assign policy     = bor_policy_e'(user_mode_i);
  assign release_ok = busoff_q && seq_done_i &&
                      ((policy == POL_AUTO) || !hold_q) && !enter_i;
  assign clear_o    = enter_i || release_ok;
  assign active_o   = busoff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busoff_q <= 1'b0;
      hold_q   <= 1'b0;
      rec_q    <= 1'b0;
    end else begin
      rec_q <= release_ok;
      if (enter_i) begin
        busoff_q <= 1'b1;
        hold_q   <= 1'b1;
      end else begin
        if (hold_clr_i) hold_q   <= 1'b0;
        if (release_ok) busoff_q <= 1'b0;
      end
    end
  end

  assign busoff_o    = busoff_q;
  assign hold_o      = hold_q;
  assign recovered_o = rec_q;

  AST_ENTRY_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enter_i |=> busoff_o && hold_o) else $error("entry missed"); // R2
  AST_USER_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busoff_o && hold_o && user_mode_i) |=> busoff_o) else $error("released under hold"); // R6
  AST_REC_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recovered_o |=> !recovered_o) else $error("pulse too long"); // R9
  AST_REC_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busoff_o) |-> recovered_o) else $error("fall without pulse"); // R9
endmodule

// File: rtl/can_busoff_recovery.sv
module can_busoff_recovery #(
  parameter int RUN_LEN    = 11,
  parameter int SEQ_TARGET = 128
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_valid_i,
  input  logic bit_val_i,
  input  logic busoff_enter_i,
  input  logic user_mode_i,
  input  logic hold_clr_i,
  output logic busoff_o,
  output logic hold_o,
  output logic recovered_o
);
  logic clear, active, occ, seq_done;

  can_bor_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .enter_i     (busoff_enter_i),
    .user_mode_i (user_mode_i),
    .hold_clr_i  (hold_clr_i),
    .seq_done_i  (seq_done),
    .busoff_o    (busoff_o),
    .hold_o      (hold_o),
    .recovered_o (recovered_o),
    .clear_o     (clear),
    .active_o    (active)
  );

  can_bor_run_cnt #(.RUN_LEN(RUN_LEN)) u_run (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (clear),
    .active_i    (active),
    .bit_valid_i (bit_valid_i),
    .bit_val_i   (bit_val_i),
    .occ_o       (occ)
  );

  can_bor_seq_cnt #(.SEQ_TARGET(SEQ_TARGET)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear),
    .inc_i   (occ),
    .done_o  (seq_done)
  );
endmodule

// File: tb/can_busoff_recovery_test.sv
module can_busoff_recovery_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bv = 1'b0, bval = 1'b0, enter = 1'b0, umode = 1'b0, hclr = 1'b0;
  logic busoff, hold, rec;
  int checks = 0, errors = 0, cyc = 0;
  string cur_req = "R1";

  // behavioural reference
  int m_run = 0, m_seq = 0;
  bit m_busoff = 0, m_hold = 0, m_rec = 0;

  always #4 clk = ~clk;

  can_busoff_recovery uut (
    .clk_i(clk), .rst_ni(rst_n), .bit_valid_i(bv), .bit_val_i(bval),
    .busoff_enter_i(enter), .user_mode_i(umode), .hold_clr_i(hclr),
    .busoff_o(busoff), .hold_o(hold), .recovered_o(rec)
  );

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at cycle %0d", req, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    if (rst_n) begin
      bit go;
      go = m_busoff && m_seq >= 128 && (!umode || !m_hold) && !enter;
      m_rec = go;
      if (enter) begin
        m_busoff = 1; m_hold = 1; m_run = 0; m_seq = 0;
      end else begin
        if (hclr) m_hold = 0;
        if (go) begin
          m_busoff = 0; m_run = 0; m_seq = 0;
        end else if (m_busoff && bv) begin
          if (bval) begin
            m_run++;
            if (m_run == 11) begin
              m_run = 0;
              if (m_seq < 128) m_seq++;
            end
          end else m_run = 0;
        end
      end
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      check({cur_req, " busoff"}, busoff, m_busoff);
      check({cur_req, " hold"}, hold, m_hold);
      check({cur_req, " recovered"}, rec, m_rec);
    end
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic send(int n, logic v);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); bv = 1'b1; bval = v;
    end
    @(negedge clk); bv = 1'b0;
  endtask

  task automatic runs(int k);
    for (int i = 0; i < k; i++) send(11, 1'b1);
  endtask

  task automatic pulse_enter();
    @(negedge clk); enter = 1'b1;
    @(negedge clk); enter = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); hclr = 1'b1;
    @(negedge clk); hclr = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 busoff", busoff, 1'b0);
    check("R1 hold", hold, 1'b0);
    check("R1 recovered", rec, 1'b0);
    @(negedge clk); rst_n = 1'b1;

    cur_req = "R10";
    runs(20);
    cur_req = "R2";
    pulse_enter();
    check("R2 busoff", busoff, 1'b1);
    check("R2 hold", hold, 1'b1);

    // auto mode with dominant breaks and strobe gaps
    cur_req = "R3/R4/R5";
    for (int i = 0; i < 10; i++) begin
      send(10, 1'b1); send(1, 1'b0);
    end
    runs(127);
    send(10, 1'b1);
    repeat (4) @(negedge clk);
    check("R4 still busoff", busoff, 1'b1);
    send(1, 1'b0);
    send(10, 1'b1);
    check("R3 short run no release", busoff, 1'b1);
    send(1, 1'b1);
    @(negedge clk);
    check("R5 released", busoff, 1'b0);
    check("R5 hold ignored", hold, 1'b1);

    // user mode: count first, clear later
    cur_req = "R6";
    umode = 1'b1;
    pulse_enter();
    runs(128);
    repeat (20) @(negedge clk);
    check("R6 held", busoff, 1'b1);
    cur_req = "R7/R9";
    pulse_clr();
    @(negedge clk);
    check("R7 released after clear", busoff, 1'b0);

    // user mode: clear first, count later
    cur_req = "R8/R7";
    pulse_enter();
    pulse_clr();
    check("R8 hold cleared", hold, 1'b0);
    runs(127);
    check("R7 before count", busoff, 1'b1);
    runs(1);
    @(negedge clk);
    check("R7 clear-first release", busoff, 1'b0);

    // entry and clear together, entry wins
    cur_req = "R8";
    @(negedge clk); enter = 1'b1; hclr = 1'b1;
    @(negedge clk); enter = 1'b0; hclr = 1'b0;
    check("R8 entry wins", hold, 1'b1);

    // re-entry midway restarts count
    cur_req = "R2/R11";
    umode = 1'b0;
    runs(100);
    pulse_enter();
    runs(100);
    check("R2 restart keeps busoff", busoff, 1'b1);
    cur_req = "R9";
    runs(28);
    @(negedge clk);
    check("R9 full fresh count", busoff, 1'b0);
    repeat (3) @(negedge clk);
    check("R9 pulse ended", rec, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule